// File: doc/BRIEF.md
# Link Activity Window Meter

This block is one measurement counter attached to a single serial link port. Firmware points it at a link condition or a payload direction by writing a report code. It then accumulates either the cycles spent in that condition, or the 16-byte payload units moved in one direction. Each measurement runs for a fixed, coded length of time or until firmware stops it. The 64-bit result is read as two 32-bit words. Reading the upper word first gives a consistent pair.

The block has three states. In `ST_IDLE` the result is held. `ST_MANUAL` counts until firmware stops it. `ST_TIMED` counts for a window of a fixed number of cycles, which is derived from the `CLK_HZ` parameter.

The transitions are as follows:
- start-manual: `ST_IDLE` or `ST_TIMED` go to `ST_MANUAL` when a control write sets enable with a manual duration code.
- start-timed: any state goes to `ST_TIMED` when a control write sets enable with a timed code. This clears the result and reloads the window.
- stop: `ST_MANUAL` or `ST_TIMED` go to `ST_IDLE` when a control write clears enable.
- expire: `ST_TIMED` goes to `ST_IDLE` when the window runs out.

Top module: `link_activity_meter`

## Requirements
- R1: The control word is at address 0x10.
  - Bits 31:24 are the report code.
  - Bits 15:8 are the duration code.
  - Bit 0 is enable. It reads back 1 while the meter is in `ST_MANUAL` or `ST_TIMED`.
  - All other bits read 0.
  - Reads return data on `reg_rdata` one cycle after the read is captured.
- R2: The result's low word is at 0x14 and its high word at 0x18.
  - Reading the high word captures the low word at the same instant.
  - The next low-word read returns that captured value.
  - Any later low-word read returns the live value.
- R3: `link_state` encodes the link condition as follows: 0 L0, 1 transmitter in L0s, 2 receiver in L0s, 3 both in L0s, 4 L1 idle, 5 L1.1, 6 L1.2, 7 configuration/recovery, 8 L1 on auxiliary power; 9 to 15 are other conditions. The report codes count one per cycle as follows:
  - 0x00 counts every cycle.
  - 0x01 counts states 1 or 3.
  - 0x02 counts states 2 or 3.
  - 0x03 counts state 0.
  - 0x04 counts states 4, 5 or 6.
  - 0x05, 0x06 and 0x07 count states 5, 6 and 7.
  - 0x08 counts state 3.
  - 0x09 counts state 8.
- R4: Report 0x20 adds one for each cycle in which `tx_unit` is high. Report 0x21 does the same for `rx_unit`. Each unit is 16 bytes of payload.
- R5: Any other report code never changes the result.
- R6: Duration code 0x00, and every code from 0x07 to 0xFE, selects manual mode.
  - Writing enable=1 resumes counting from the held result.
  - One count is added in each qualifying cycle, from the cycle after that write up to and including the cycle in which an enable=0 write is captured.
  - After that the result stays frozen.
- R7: The timed codes and their window lengths are: 0x01 1 ms, 0x02 10 ms, 0x03 100 ms, 0x04 1 s, 0x05 2 s, 0x06 4 s, 0xFF 4 us.
  - The window is `CLK_HZ` times the duration, in cycles, with a minimum of 1.
  - An enable=1 write clears the result and then counts over exactly that many cycles.
  - Enable then reads 0 and the result is held.
- R8: During a timed window, an enable=1 write restarts the window and clears the result. An enable=0 write stops the count at the cycle in which it is captured.
- R9: Reset (`rst_n` low, asynchronous) sets the state to `ST_IDLE` and sets all control fields and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| link_state | input | 4 | Encoded current link condition |
| tx_unit | input | 1 | One transmitted 16-byte payload unit this cycle |
| rx_unit | input | 1 | One received 16-byte payload unit this cycle |

## Verification
The assertions check the following properties on every cycle:
- The result moves by at most one per cycle.
- The result is frozen in `ST_IDLE`.
- A timed start leaves the result at zero.
- A stop write always lands in `ST_IDLE`.
- A window that runs out returns the meter to `ST_IDLE`.

Only the bench scenarios can show the rest. These are the exact count for each report code against every link state, the window lengths themselves, and that the result resumes after a manual stop. They also cover the high/low snapshot pairing and that the enable bit reads back cleared after expiry.

// File: rtl/lam_pkg.sv
package lam_pkg;
    localparam int LS_W   = 4;
    localparam int WORD_W = 32;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_MANUAL, ST_TIMED} meter_state_e;

    // register addresses
    localparam logic [7:0] ADDR_CTRL = 8'h10;
    localparam logic [7:0] ADDR_LO   = 8'h14;
    localparam logic [7:0] ADDR_HI   = 8'h18;

    // link condition encoding
    localparam logic [LS_W-1:0] LS_L0       = 4'd0;
    localparam logic [LS_W-1:0] LS_L0S_TX   = 4'd1;
    localparam logic [LS_W-1:0] LS_L0S_RX   = 4'd2;
    localparam logic [LS_W-1:0] LS_L0S_BOTH = 4'd3;
    localparam logic [LS_W-1:0] LS_L1_IDLE  = 4'd4;
    localparam logic [LS_W-1:0] LS_L1_SUB1  = 4'd5;
    localparam logic [LS_W-1:0] LS_L1_SUB2  = 4'd6;
    localparam logic [LS_W-1:0] LS_CFG_RCV  = 4'd7;
    localparam logic [LS_W-1:0] LS_L1_AUXP  = 4'd8;

    // report codes
    localparam logic [CODE_W-1:0] RP_ALL      = 8'h00;
    localparam logic [CODE_W-1:0] RP_TX_L0S   = 8'h01;
    localparam logic [CODE_W-1:0] RP_RX_L0S   = 8'h02;
    localparam logic [CODE_W-1:0] RP_L0       = 8'h03;
    localparam logic [CODE_W-1:0] RP_L1_ANY   = 8'h04;
    localparam logic [CODE_W-1:0] RP_L1_SUB1  = 8'h05;
    localparam logic [CODE_W-1:0] RP_L1_SUB2  = 8'h06;
    localparam logic [CODE_W-1:0] RP_CFG_RCV  = 8'h07;
    localparam logic [CODE_W-1:0] RP_BOTH_L0S = 8'h08;
    localparam logic [CODE_W-1:0] RP_L1_AUXP  = 8'h09;
    localparam logic [CODE_W-1:0] RP_TX_DATA  = 8'h20;
    localparam logic [CODE_W-1:0] RP_RX_DATA  = 8'h21;

    // duration codes that run a fixed window
    function automatic logic dur_is_timed(input logic [CODE_W-1:0] code);
        return ((code >= 8'h01) && (code <= 8'h06)) || (code == 8'hFF);
    endfunction
endpackage

// File: rtl/lam_event_mux.sv
module lam_event_mux
    import lam_pkg::*;
(
    input  logic [CODE_W-1:0] report_sel,
    input  logic [LS_W-1:0]   link_state,
    input  logic              tx_unit,
    input  logic              rx_unit,
    output logic              hit
);
    always_comb begin
        case (report_sel)
            RP_ALL:      hit = 1'b1;
            RP_TX_L0S:   hit = (link_state == LS_L0S_TX) || (link_state == LS_L0S_BOTH);
            RP_RX_L0S:   hit = (link_state == LS_L0S_RX) || (link_state == LS_L0S_BOTH);
            RP_L0:       hit = (link_state == LS_L0);
            RP_L1_ANY:   hit = (link_state == LS_L1_IDLE) || (link_state == LS_L1_SUB1)
                               || (link_state == LS_L1_SUB2);
            RP_L1_SUB1:  hit = (link_state == LS_L1_SUB1);
            RP_L1_SUB2:  hit = (link_state == LS_L1_SUB2);
            RP_CFG_RCV:  hit = (link_state == LS_CFG_RCV);
            RP_BOTH_L0S: hit = (link_state == LS_L0S_BOTH);
            RP_L1_AUXP:  hit = (link_state == LS_L1_AUXP);
            RP_TX_DATA:  hit = tx_unit;
            RP_RX_DATA:  hit = rx_unit;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lam_window_timer.sv
module lam_window_timer
    import lam_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] dur_code,
    input  logic              run,
    output logic              done
);
    localparam longint unsigned MAX_LEN = 64'd4 * CLK_HZ;
    localparam int TMR_W = $clog2(MAX_LEN + 64'd1);

    logic [TMR_W-1:0] remain_q;

    function automatic logic [TMR_W-1:0] last_index(input logic [CODE_W-1:0] code);
        longint unsigned n;
        case (code)
            8'h01:   n = CLK_HZ / 64'd1000;
            8'h02:   n = CLK_HZ / 64'd100;
            8'h03:   n = CLK_HZ / 64'd10;
            8'h04:   n = CLK_HZ;
            8'h05:   n = 64'd2 * CLK_HZ;
            8'h06:   n = 64'd4 * CLK_HZ;
            8'hFF:   n = (64'd4 * CLK_HZ) / 64'd1_000_000;
            default: n = 64'd1;
        endcase
        if (n == 64'd0) n = 64'd1;
        return TMR_W'(n - 64'd1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= last_index(dur_code);
        else if (run && (remain_q != '0))
            remain_q <= remain_q - 1'b1;
    end

    assign done = (remain_q == '0);
endmodule

// File: rtl/link_activity_meter.sv
module link_activity_meter
    import lam_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd100_000_000,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        link_state,
    input  logic              tx_unit,
    input  logic              rx_unit
);
    localparam int ACC_W = 2 * WORD_W;

    meter_state_e      state_q, state_d;
    logic [CODE_W-1:0] rpt_q, dur_q;
    logic [ACC_W-1:0]  acc_q;
    logic [WORD_W-1:0] snap_q, rdata_q;
    logic              snap_vld_q;

    logic ctrl_wr, start, stop, new_timed;
    logic hit, win_done, counting, en_bit, load_win;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign start     = ctrl_wr && reg_wdata[0];
    assign stop      = ctrl_wr && !reg_wdata[0];
    assign new_timed = dur_is_timed(reg_wdata[15:8]);
    assign load_win  = start && new_timed;

    lam_event_mux u_mux (
        .report_sel (rpt_q),
        .link_state (link_state),
        .tx_unit    (tx_unit),
        .rx_unit    (rx_unit),
        .hit        (hit)
    );

    lam_window_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_win),
        .dur_code (reg_wdata[15:8]),
        .run      (state_q == ST_TIMED),
        .done     (win_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = new_timed ? ST_TIMED : ST_MANUAL;
            ST_MANUAL: begin
                if (stop)                        state_d = ST_IDLE;
                else if (start && new_timed)     state_d = ST_TIMED;
            end
            ST_TIMED: begin
                if (stop)          state_d = ST_IDLE;
                else if (start)    state_d = new_timed ? ST_TIMED : ST_MANUAL;
                else if (win_done) state_d = ST_IDLE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // state-decoded outputs
    always_comb begin
        counting = (state_q != ST_IDLE);
        en_bit   = counting;
    end

    // control fields and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_q <= '0;
            dur_q <= '0;
            acc_q <= '0;
        end else begin
            if (ctrl_wr) begin
                rpt_q <= reg_wdata[31:24];
                dur_q <= reg_wdata[15:8];
            end
            if (load_win)
                acc_q <= '0;
            else if (counting && hit)
                acc_q <= acc_q + 1'b1;
        end
    end

    // register reads with high-word snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else if (reg_rd) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
                rdata_q <= {rpt_q, 8'h00, dur_q, 7'h00, en_bit};
            end else if (reg_addr == ADDR_W'(ADDR_LO)) begin
                rdata_q    <= snap_vld_q ? snap_q : acc_q[WORD_W-1:0];
                snap_vld_q <= 1'b0;
            end else if (reg_addr == ADDR_W'(ADDR_HI)) begin
                rdata_q    <= acc_q[ACC_W-1:WORD_W];
                snap_q     <= acc_q[WORD_W-1:0];
                snap_vld_q <= 1'b1;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign reg_rdata = rdata_q;

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_win |=> (acc_q == $past(acc_q)) || (acc_q == $past(acc_q) + 1'b1));

    assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(acc_q));

    assert_timed_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_win |=> (acc_q == '0));

    assert_expire_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMED && win_done && !ctrl_wr) |=> (state_q == ST_IDLE));

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == ST_IDLE));
endmodule

// File: tb/link_activity_meter_test.sv
module link_activity_meter_test;
    localparam longint unsigned HZ = 64'd1_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [3:0]  link_state = 4'd0;
    logic        tx_unit = 1'b0, rx_unit = 1'b0;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    link_activity_meter #(.CLK_HZ(HZ), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_state(link_state), .tx_unit(tx_unit), .rx_unit(rx_unit)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; captured at the next rising edge
    task automatic wr_ctrl(input logic [7:0] rpt, input logic [7:0] dur, input logic en);
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = {rpt, 8'h00, dur, 7'h00, en};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata; reg_rd = 1'b0;
    endtask

    task automatic rd64(output logic [63:0] v);
        logic [31:0] h, l;
        rd(8'h18, h);
        rd(8'h14, l);
        v = {h, l};
    endtask

    function automatic logic exp_hit(input logic [7:0] r, input logic [3:0] s,
                                     input logic t, input logic x);
        case (r)
            8'h00: return 1'b1;
            8'h01: return s == 1 || s == 3;
            8'h02: return s == 2 || s == 3;
            8'h03: return s == 0;
            8'h04: return s == 4 || s == 5 || s == 6;
            8'h05: return s == 5;
            8'h06: return s == 6;
            8'h07: return s == 7;
            8'h08: return s == 3;
            8'h09: return s == 8;
            8'h20: return t;
            8'h21: return x;
            default: return 1'b0;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d, l1, l2, l3;
        logic [63:0] v0, v1, v2;
        logic [7:0]  codes [16];
        codes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                  8'h08, 8'h09, 8'h20, 8'h21, 8'h0A, 8'h1F, 8'h22, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        rd(8'h10, d); check("R9 ctrl after reset", d, 0);
        rd64(v0);     check("R9 result after reset", v0, 0);

        // R1: control readback
        wr_ctrl(8'hA5, 8'h00, 1'b1);
        rd(8'h10, d); check("R1 ctrl running", d, 32'hA500_0001);
        wr_ctrl(8'h5A, 8'h07, 1'b0);
        rd(8'h10, d); check("R1 ctrl stopped", d, 32'h5A00_0700);

        // R3 R4 R5 R6: sweep of link state x report code, manual windows
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                int g;
                logic [7:0] dcode;
                string tag;
                g = 3 + (s % 4);
                dcode = (s >= 8) ? 8'h07 : 8'h00;
                link_state = 4'(s); tx_unit = s[0]; rx_unit = ~s[0];
                rd64(v0);
                wr_ctrl(codes[c], dcode, 1'b1);
                repeat (g) @(negedge clk);
                wr_ctrl(codes[c], dcode, 1'b0);
                rd64(v1);
                tag = (codes[c] <= 8'h09) ? "R3 state count" :
                      (codes[c] == 8'h20 || codes[c] == 8'h21) ? "R4 payload count" :
                      "R5 unlisted code";
                check(tag, v1 - v0,
                      exp_hit(codes[c], 4'(s), s[0], ~s[0]) ? 64'(g + 1) : 64'd0);
            end
        end

        // R6: freeze after stop, then resume
        link_state = 4'd0; tx_unit = 1'b1; rx_unit = 1'b1;
        rd64(v0);
        wr_ctrl(8'h00, 8'h00, 1'b1);
        repeat (4) @(negedge clk);
        wr_ctrl(8'h00, 8'h00, 1'b0);
        rd64(v1); check("R6 manual count", v1 - v0, 5);
        repeat (10) @(negedge clk);
        rd64(v2); check("R6 frozen after stop", v2, v1);
        rd(8'h10, d); check("R6 enable cleared", d, 32'h0);
        wr_ctrl(8'h00, 8'h00, 1'b1);
        repeat (2) @(negedge clk);
        wr_ctrl(8'h00, 8'h00, 1'b0);
        rd64(v0); check("R6 resume from held", v0 - v2, 3);

        // R7: 4 us window clears the earlier nonzero result
        wr_ctrl(8'h00, 8'hFF, 1'b1);
        repeat (8) @(negedge clk);
        rd64(v0); check("R7 4us window", v0, 4);
        rd(8'h10, d); check("R7 enable cleared on expiry", d, 32'h0000_FF00);

        // R7: 1 ms window, every cycle
        wr_ctrl(8'h00, 8'h01, 1'b1);
        repeat (1010) @(negedge clk);
        rd64(v0); check("R7 1ms window", v0, 1000);

        // R7: 10 ms window counting L0
        link_state = 4'd0;
        wr_ctrl(8'h03, 8'h02, 1'b1);
        repeat (10010) @(negedge clk);
        rd64(v0); check("R7 10ms window L0", v0, 10000);

        // R4 R7: 1 ms window of alternate transmit units
        wr_ctrl(8'h20, 8'h01, 1'b1);
        for (int i = 0; i < 1005; i++) begin
            tx_unit = (i % 2 == 0) && (i < 1000);
            @(negedge clk);
        end
        tx_unit = 1'b0;
        rd64(v0); check("R4 timed tx units", v0, 500);

        // R8: restart during a window
        wr_ctrl(8'h00, 8'h01, 1'b1);
        repeat (100) @(negedge clk);
        wr_ctrl(8'h00, 8'hFF, 1'b1);
        repeat (8) @(negedge clk);
        rd64(v0); check("R8 restart clears", v0, 4);

        // R8: early stop of a window
        wr_ctrl(8'h00, 8'h01, 1'b1);
        repeat (20) @(negedge clk);
        wr_ctrl(8'h00, 8'h01, 1'b0);
        rd64(v0); check("R8 early stop count", v0, 21);
        repeat (30) @(negedge clk);
        rd64(v1); check("R8 held after stop", v1, 21);

        // R2: high read captures low word
        wr_ctrl(8'h00, 8'h00, 1'b1);
        rd(8'h18, d); check("R2 high word", d, 0);
        repeat (5) @(negedge clk);
        rd(8'h14, l1);
        rd(8'h14, l2);
        rd(8'h14, l3);
        check("R2 snapshot low word", l2 - l1, 7);
        check("R2 live low word", l3 - l2, 1);

        // R9: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h10, d); check("R9 ctrl after mid-run reset", d, 0);
        rd64(v0);     check("R9 result after mid-run reset", v0, 0);

        finish_run();
    end
endmodule